// File: doc/BRIEF.md
# Vector Fail-First Length Truncation Unit

This block applies data-dependent fail-first to one vector operation. After a start pulse it walks the elements in index order, one element per cycle, from element 0 up to the requested length minus one. Each element brings a predicate bit and two possible failure sources: a condition-test failure and a floating-point exception flag. A mode input picks which source counts. The first active element whose selected source reports a failure ends the scan, and the vector length is cut at that point.

An inclusive/exclusive control decides two things. It sets whether the failing element stays inside the new length. It also sets whether that element's floating-point exception is ever signalled. This keeps the outcome deterministic: in exclusive mode the length stops just before the fault, so the fault is never signalled. In inclusive mode the faulting element is kept and its exception always fires.

When the scan ends the block pulses `done` and holds its outputs until the next start. The outputs are the new length, per-element destination write enables, zero-write controls, condition-register write enables, and a one-cycle exception-raise strobe. The surrounding datapath uses these to commit results. Arithmetic, register storage, sub-vector packing and reductions are handled elsewhere.

Top module: `ff_trunc_unit`

## Requirements
- R1: The truncation point is the lowest-index element i < the effective length with `pred[i]`=1 and its selected failure bit =1. Elements with `pred[i]`=0 never count as failures.
- R2: With `incl`=1 and a failure at element i, `vl_out` = i+1.
- R3: With `incl`=0 and a failure at element i, `vl_out` = i. Element i receives no destination write.
- R4: With no failure, `vl_out` equals the effective length and `exc_raise` stays all-zero.
- R5: `exc_raise` bit i is 1 only in the `done` cycle, and only when `fp_mode`=1, `incl`=1 and element i is the failing element. At other times it is zero.
- R6: `dest_we[i]` is 1 only for i < `vl_out`. Within that range it is 1 when the element is active and did not fail, or when `zero_en`=1.
- R7: `dest_zero[i]` is 1 for i < `vl_out` when `zero_en`=1 and the element is either masked out or is the failing element.
- R8: With `rc_en`=1, `cr_we[i]` is 1 for every active element up to and including the failing element, or up to the effective length minus 1 when nothing fails. This holds in both inclusive and exclusive modes.
- R9: A start with effective length 0 gives `done` in the next cycle, with `vl_out`=0 and no write enables.
- R10: `done` is a one-cycle pulse k+1 cycles after the start edge, where k is the number of elements scanned (counting the edge that samples start as cycle 1). `vl_out` holds steady from `done` until the next start.
- R11: `fp_mode`=1 selects `fp_exc` as the failure source. `fp_mode`=0 selects `test_fail`.
- R12: A requested length above MAXVL is treated as MAXVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan; all other inputs are sampled with it |
| vl_in | input | VLW | Requested vector length |
| incl | input | 1 | 1 = failing element kept in the length |
| zero_en | input | 1 | Predicate zeroing enable |
| rc_en | input | 1 | Condition recording enable |
| fp_mode | input | 1 | 1 = failure source is the FP exception flag |
| pred | input | MAXVL | Per-element predicate mask |
| test_fail | input | MAXVL | Per-element condition-test failure |
| fp_exc | input | MAXVL | Per-element FP exception flag |
| done | output | 1 | One-cycle completion pulse |
| vl_out | output | VLW | Truncated vector length |
| dest_we | output | MAXVL | Destination write enables |
| dest_zero | output | MAXVL | Write zero instead of the result |
| cr_we | output | MAXVL | Condition-register element write enables |
| exc_raise | output | MAXVL | Exception raise strobe, valid with done |

## Verification
A wrong scan index or a missed hit shows up in two ways at once. The `done` pulse arrives in the wrong cycle, and `vl_out` is wrong. Both are visible within one cycle of the point where the first failure should have ended the scan. A wrongly held failure flag or failing index corrupts the write-enable, zero and condition masks for the whole period until the next start, so every completed operation exposes it. A stale length register shows up as `vl_out` moving while idle, or as enables set beyond the length.

// File: rtl/ff_trunc_pkg.sv
// Shared definitions for the fail-first truncation unit.
package ff_trunc_pkg;
    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_RUN  = 1'b1
    } scan_state_e;
endpackage

// File: rtl/ff_scan.sv
// Element scanner: visits one element per cycle in index order and stops at
// the first element whose hit bit is set, or after the last element.
// Assumes vl_start <= MAXVL and that hit/incl are stable while running.
module ff_scan #(
    parameter int MAXVL = 8,
    localparam int VLW = $clog2(MAXVL + 1),
    localparam int IW  = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VLW-1:0]   vl_start,
    input  logic [MAXVL-1:0] hit,
    input  logic             incl,
    output logic             done,
    output logic [VLW-1:0]   vl_out,
    output logic             found,
    output logic [IW-1:0]    fidx,
    output logic             running
);
    import ff_trunc_pkg::*;

    scan_state_e          state;
    logic [IW-1:0]        idx;
    logic [VLW-1:0]       len_q;
    logic                 at_last;

    // Flags the last element of the requested length.
    always_comb at_last = (VLW'(idx) == len_q - VLW'(1));

    // Scan state, element index and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SC_IDLE;
            idx    <= '0;
            len_q  <= '0;
            done   <= 1'b0;
            vl_out <= '0;
            found  <= 1'b0;
            fidx   <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                idx   <= '0;
                len_q <= vl_start;
                found <= 1'b0;
                fidx  <= '0;
                if (vl_start == '0) begin
                    vl_out <= '0;
                    done   <= 1'b1;
                    state  <= SC_IDLE;
                end else begin
                    state <= SC_RUN;
                end
            end else if (state == SC_RUN) begin
                if (hit[idx]) begin
                    found  <= 1'b1;
                    fidx   <= idx;
                    vl_out <= incl ? VLW'(idx) + VLW'(1) : VLW'(idx);
                    done   <= 1'b1;
                    state  <= SC_IDLE;
                end else if (at_last) begin
                    vl_out <= len_q;
                    done   <= 1'b1;
                    state  <= SC_IDLE;
                end else begin
                    idx <= idx + IW'(1);
                end
            end
        end
    end

    assign running = (state == SC_RUN);
endmodule

// File: rtl/ff_mask.sv
// Per-element enable generator: turns the scan result into destination,
// zeroing, condition-register and exception controls.
// Assumes found/fidx/vl are held from done until the next start.
module ff_mask #(
    parameter int MAXVL = 8,
    localparam int VLW = $clog2(MAXVL + 1),
    localparam int IW  = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
    input  logic [VLW-1:0]   vl,
    input  logic             found,
    input  logic [IW-1:0]    fidx,
    input  logic [MAXVL-1:0] pred,
    input  logic             incl,
    input  logic             zero_en,
    input  logic             rc_en,
    input  logic             fp_mode,
    input  logic             done,
    output logic [MAXVL-1:0] dest_we,
    output logic [MAXVL-1:0] dest_zero,
    output logic [MAXVL-1:0] cr_we,
    output logic [MAXVL-1:0] exc_raise
);
    for (genvar i = 0; i < MAXVL; i++) begin : g_elem
        logic in_len, failed, eff, scanned;
        // Element classification relative to the scan result.
        always_comb begin
            in_len  = VLW'(i) < vl;
            failed  = found && (fidx == IW'(i));
            eff     = pred[i] && !failed;
            scanned = found ? (VLW'(i) <= VLW'(fidx)) : in_len;
        end
        // Output enables for this element.
        always_comb begin
            dest_we[i]   = in_len && (eff || zero_en);
            dest_zero[i] = in_len && zero_en && !eff;
            cr_we[i]     = rc_en && pred[i] && scanned;
            exc_raise[i] = done && fp_mode && incl && failed;
        end
    end
endmodule

// File: rtl/ff_trunc_unit.sv
// Fail-first truncation unit top: samples the operation on start, selects the
// failure source, runs the scanner and drives the per-element controls.
// Assumes the controls are only read between done and the next start.
module ff_trunc_unit #(
    parameter int MAXVL = 8,
    localparam int VLW = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VLW-1:0]   vl_in,
    input  logic             incl,
    input  logic             zero_en,
    input  logic             rc_en,
    input  logic             fp_mode,
    input  logic [MAXVL-1:0] pred,
    input  logic [MAXVL-1:0] test_fail,
    input  logic [MAXVL-1:0] fp_exc,
    output logic             done,
    output logic [VLW-1:0]   vl_out,
    output logic [MAXVL-1:0] dest_we,
    output logic [MAXVL-1:0] dest_zero,
    output logic [MAXVL-1:0] cr_we,
    output logic [MAXVL-1:0] exc_raise
);
    localparam int IW = (MAXVL > 1) ? $clog2(MAXVL) : 1;

    logic [MAXVL-1:0] pred_q, src_q, hit;
    logic             incl_q, zero_q, rc_q, fp_q;
    logic [VLW-1:0]   vl_clamp, vl_cap;
    logic             found, scan_running;
    logic [IW-1:0]    fidx;

    // Limits the requested length to the supported maximum.
    always_comb vl_clamp = (vl_in > VLW'(MAXVL)) ? VLW'(MAXVL) : vl_in;

    // Samples the operation's masks and modes on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q <= '0;
            src_q  <= '0;
            incl_q <= 1'b0;
            zero_q <= 1'b0;
            rc_q   <= 1'b0;
            fp_q   <= 1'b0;
            vl_cap <= '0;
        end else if (start) begin
            pred_q <= pred;
            src_q  <= fp_mode ? fp_exc : test_fail;
            incl_q <= incl;
            zero_q <= zero_en;
            rc_q   <= rc_en;
            fp_q   <= fp_mode;
            vl_cap <= vl_clamp;
        end
    end

    // Active elements whose selected failure flag is set.
    always_comb hit = pred_q & src_q;

    ff_scan #(.MAXVL(MAXVL)) u_scan (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_start(vl_clamp),
        .hit(hit), .incl(incl_q), .done(done), .vl_out(vl_out),
        .found(found), .fidx(fidx), .running(scan_running)
    );

    ff_mask #(.MAXVL(MAXVL)) u_mask (
        .vl(vl_out), .found(found), .fidx(fidx), .pred(pred_q),
        .incl(incl_q), .zero_en(zero_q), .rc_en(rc_q), .fp_mode(fp_q),
        .done(done), .dest_we(dest_we), .dest_zero(dest_zero),
        .cr_we(cr_we), .exc_raise(exc_raise)
    );
endmodule

// File: rtl/ff_trunc_unit_chk.sv
// Property checker for the truncation unit, attached by bind.
module ff_trunc_unit_chk #(
    parameter int MAXVL = 8,
    localparam int VLW = $clog2(MAXVL + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [VLW-1:0]   vl_in,
    input logic             done,
    input logic [VLW-1:0]   vl_out,
    input logic [MAXVL-1:0] dest_we,
    input logic [MAXVL-1:0] dest_zero,
    input logic [MAXVL-1:0] exc_raise,
    input logic             running,
    input logic [VLW-1:0]   vl_cap
);
    // R5
    exc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(exc_raise));
    // R5
    exc_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_raise != '0) |-> done);
    // R7
    zero_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dest_zero & ~dest_we) == '0);
    // R6
    we_in_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((dest_we >> vl_out) == '0));
    // R12
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vl_out <= vl_cap && vl_cap <= VLW'(MAXVL)));
    // R9
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && vl_in == '0) |=> (done && vl_out == '0));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !running) |=> $stable(vl_out));
endmodule

bind ff_trunc_unit ff_trunc_unit_chk #(.MAXVL(MAXVL)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .done(done),
    .vl_out(vl_out), .dest_we(dest_we), .dest_zero(dest_zero),
    .exc_raise(exc_raise), .running(scan_running), .vl_cap(vl_cap)
);

// File: tb/ff_trunc_unit_test.sv
// Near-exhaustive sweep: every failure pattern against several predicate
// masks, lengths and mode mixes, with results predicted arithmetically.
module ff_trunc_unit_test;
    localparam int MAXVL = 8;
    localparam int VLW = $clog2(MAXVL + 1);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [VLW-1:0] vl_in = '0;
    logic incl = 1'b0, zero_en = 1'b0, rc_en = 1'b0, fp_mode = 1'b0;
    logic [MAXVL-1:0] pred = '0, test_fail = '0, fp_exc = '0;
    logic done;
    logic [VLW-1:0] vl_out;
    logic [MAXVL-1:0] dest_we, dest_zero, cr_we, exc_raise;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    ff_trunc_unit #(.MAXVL(MAXVL)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .incl(incl),
        .zero_en(zero_en), .rc_en(rc_en), .fp_mode(fp_mode), .pred(pred),
        .test_fail(test_fail), .fp_exc(fp_exc), .done(done), .vl_out(vl_out),
        .dest_we(dest_we), .dest_zero(dest_zero), .cr_we(cr_we),
        .exc_raise(exc_raise)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs one operation and compares all outputs with the prediction.
    task automatic run_op(input int vl, input logic [MAXVL-1:0] p,
                          input logic [MAXVL-1:0] tf, input logic [MAXVL-1:0] fe,
                          input logic inc, input logic ze, input logic rc,
                          input logic fp, input logic hold_test);
        int veff, fidx, vexp, lat, scanned;
        logic fnd;
        logic [MAXVL-1:0] src, e_we, e_zero, e_cr, e_exc;
        logic [VLW-1:0] held_vl;
        logic [MAXVL-1:0] held_we;
        // R12 clamp, R11 source select, R1 first active failure
        veff = (vl > MAXVL) ? MAXVL : vl;
        src = fp ? fe : tf;
        fnd = 1'b0; fidx = 0;
        for (int i = 0; i < veff; i++)
            if (!fnd && p[i] && src[i]) begin fnd = 1'b1; fidx = i; end
        vexp = fnd ? (inc ? fidx + 1 : fidx) : veff;
        scanned = fnd ? fidx + 1 : veff;
        for (int i = 0; i < MAXVL; i++) begin
            logic failed, eff, inl;
            failed = fnd && (i == fidx);
            eff = p[i] && !failed;
            inl = i < vexp;
            e_we[i]   = inl && (eff || ze);
            e_zero[i] = inl && ze && !eff;
            e_cr[i]   = rc && p[i] && (fnd ? (i <= fidx) : (i < veff));
            e_exc[i]  = fp && inc && failed;
        end
        @(negedge clk);
        vl_in = VLW'(vl); pred = p; test_fail = tf; fp_exc = fe;
        incl = inc; zero_en = ze; rc_en = rc; fp_mode = fp; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R10 watchdog: done missing actual=0 expected=1");
            return;
        end
        chk("R10 latency", lat, scanned + 1);
        chk(inc ? "R2/R4 length" : "R3/R4 length", int'(vl_out), vexp);
        chk("R6 dest_we", int'(dest_we), int'(e_we));
        chk("R7 dest_zero", int'(dest_zero), int'(e_zero));
        chk("R8 cr_we", int'(cr_we), int'(e_cr));
        chk("R5 exc_raise", int'(exc_raise), int'(e_exc));
        @(negedge clk);
        chk("R5 exc_raise after done", int'(exc_raise), 0);
        if (hold_test) begin
            held_vl = vl_out; held_we = dest_we;
            repeat (3) @(negedge clk);
            chk("R10 hold vl_out", int'(vl_out), int'(held_vl));
            chk("R10 hold dest_we", int'(dest_we), int'(held_we));
        end
    endtask

    initial begin
        logic [MAXVL-1:0] pats [3];
        pats[0] = 8'hFF; pats[1] = 8'hA5; pats[2] = 8'h3C;
        repeat (3) @(negedge clk);
        // Reset state
        chk("R10 reset done", int'(done), 0);
        chk("R10 reset vl_out", int'(vl_out), 0);
        chk("R6 reset dest_we", int'(dest_we), 0);
        chk("R5 reset exc_raise", int'(exc_raise), 0);
        rst_n = 1'b1;
        // R9 zero length with every enable requested
        run_op(0, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        // R1 masked-out failures ignored; R4 no failure full length
        run_op(8, 8'h00, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        // R2 inclusive FP fault at element 3 raises it; R3 exclusive does not
        run_op(8, 8'hFF, 8'h00, 8'h08, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        run_op(8, 8'hFF, 8'h00, 8'h08, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        // R12 over-length request
        run_op(15, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        // Sweep: every failure pattern, three masks, four mode mixes
        for (int pi = 0; pi < 3; pi++)
            for (int f = 0; f < 256; f++)
                for (int m = 0; m < 4; m++) begin
                    logic [7:0] fb;
                    fb = 8'(f);
                    run_op(m[1] ? 8 : (f + pi + m) % 10, pats[pi], fb, ~fb,
                           m[0], fb[0] ^ m[1], fb[6] ^ m[0], fb[3] ^ m[1],
                           (f % 61) == 0);
                end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Global watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule